// File: doc/BRIEF.md
# Clock Select and Glitch-Free Fanout

This block picks one of two clock sources and copies it to several identical outputs. The first source is a fast system clock. The second is a slower scan or test clock. A select input chooses the source. An active-low common enable turns the outputs on or off.

The enable is not applied directly to the outputs. A flip-flop captures it on the falling edge of whichever clock is currently selected. Each output is the selected clock ANDed with that registered flag. The gate can therefore change only while the clock is already low. Turning the outputs on or off never cuts a high pulse short.

An active-low asynchronous reset forces the flag to the disabled state. The select input is meant to sit on a pulled-down board line, so an undriven line selects the system clock. Changing the select input while the outputs are enabled is not allowed; it is the user's responsibility.

Top module: `clkfan_top`

## Requirements
- R1: With `sel_scan` low, the outputs carry `sys_clk`: every enabled high pulse lasts one half period of `sys_clk`.
- R2: With `sel_scan` high, the outputs carry `scan_clk`: every enabled high pulse lasts one half period of `scan_clk`.
- R3: When the select line is left undriven and only pulled low, the outputs carry `sys_clk`.
- R4: While the registered enable is inactive (after `en_n` was seen high at a falling edge), every output stays low.
- R5: When `en_n` goes low, the outputs first pass the clock in the high phase that follows the next falling edge of the selected clock. Before that edge they stay low.
- R6: When `en_n` goes high, any high phase already under way or starting before the next falling edge completes in full. The outputs are low from that falling edge on.
- R7: All `NUM_OUT` outputs carry identical values at all times.
- R8: No output ever shows a high pulse shorter than one half period of the selected clock.
- R9: While `rst_n` is low, every output is low, independent of the clocks and `en_n`. After release, the outputs stay low until an enable is captured.
- R10: Whenever the selected clock is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Fast system clock source |
| scan_clk | input | 1 | Slow scan/test clock source |
| sel_scan | input | 1 | Source select: 0 = system clock, 1 = scan clock |
| en_n | input | 1 | Active-low common output enable, captured on falling edge of the selected clock |
| rst_n | input | 1 | Active-low asynchronous reset, forces the outputs disabled |
| clk_out | output | NUM_OUT (5) | Gated copies of the selected clock |

## Verification
The only internal state is the one-bit gate flag. If that flag is wrong, the error shows at the ports within one high phase of the selected clock. A stuck flag leaves all outputs dead or free-running. A flag captured on the wrong edge or at the wrong time makes the outputs start or stop one phase early or late, or produces a truncated first or last pulse. The bench therefore sweeps the arrival time of each enable change across the whole period of both clocks. It samples the outputs in the high phases right around the capturing edge and measures the width of every pulse. A mis-wired source selection shows up at once as a pulse width equal to the other clock's half period.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int unsigned DEF_NUM_OUT = 5;

    typedef struct packed {
        logic gate_on;
    } gate_state_t;

    localparam gate_state_t GATE_RESET = '{gate_on: 1'b0};

endpackage

// File: rtl/clkfan_mux.sv
module clkfan_mux (
    input  logic sys_clk,
    input  logic scan_clk,
    input  logic sel_scan,
    output logic clk_sel
);

    always_comb begin
        clk_sel = sel_scan ? scan_clk : sys_clk;
    end

endmodule

// File: rtl/clkfan_en_sync.sv
module clkfan_en_sync
    import clkfan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    output logic gate_on
);

    gate_state_t state_d;
    gate_state_t state_q;

    always_comb begin
        state_d         = state_q;
        state_d.gate_on = ~en_n;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign gate_on = state_q.gate_on;

    // R5 R6
    en_edge_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !$stable(en_n) |=> (gate_on == !$past(en_n)));

endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate #(
    parameter int unsigned NUM_OUT = 5
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic               gate_on,
    output logic [NUM_OUT-1:0] clk_out
);

    localparam logic [NUM_OUT-1:0] ALL_ON = {NUM_OUT{1'b1}};

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_fan
        assign clk_out[i] = clk_in & gate_on;
    end

    // R7
    all_equal_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (clk_out == '0) || (clk_out == ALL_ON));

    // R10
    low_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        clk_out == '0);

    // R4
    high_phase_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
        clk_out == (gate_on ? ALL_ON : '0));

    // R9
    always @(posedge clk_in) begin
        if (rst_n === 1'b0) begin
            reset_low_chk: assert (clk_out == '0);
        end
    end

endmodule

// File: rtl/clkfan_top.sv
module clkfan_top
    import clkfan_pkg::*;
#(
    parameter int unsigned NUM_OUT = DEF_NUM_OUT
) (
    input  logic               sys_clk,
    input  logic               scan_clk,
    input  logic               sel_scan,
    input  logic               en_n,
    input  logic               rst_n,
    output logic [NUM_OUT-1:0] clk_out
);

    logic clk_sel;
    logic gate_on;

    clkfan_mux u_mux (
        .sys_clk  (sys_clk),
        .scan_clk (scan_clk),
        .sel_scan (sel_scan),
        .clk_sel  (clk_sel)
    );

    clkfan_en_sync u_en_sync (
        .clk     (clk_sel),
        .rst_n   (rst_n),
        .en_n    (en_n),
        .gate_on (gate_on)
    );

    clkfan_gate #(
        .NUM_OUT (NUM_OUT)
    ) u_gate (
        .clk_in  (clk_sel),
        .rst_n   (rst_n),
        .gate_on (gate_on),
        .clk_out (clk_out)
    );

endmodule

// File: tb/clkfan_top_bench.sv
`timescale 1ns/1ps
module clkfan_top_bench;

    localparam int  NUM = 5;
    localparam real SYS_HALF  = 2.5;
    localparam real SCAN_HALF = 20.0;
    localparam logic [NUM-1:0] ONES = {NUM{1'b1}};

    logic sys_clk  = 1'b0;
    logic scan_clk = 1'b0;
    logic sel_drv  = 1'b0;
    logic sel_oe   = 1'b0;
    logic en_n     = 1'b1;
    logic rst_n    = 1'b0;
    logic cur_sel  = 1'b0;
    logic mon_on   = 1'b0;
    real  cur_half = SYS_HALF;
    realtime rise_t = 0.0;
    logic [NUM-1:0] clk_out;
    int n_tests = 0;
    int n_fail  = 0;

    // R3: board pull-down model on the select line
    wire sel_line = sel_oe ? sel_drv : 1'b0;
    wire ref_clk  = cur_sel ? scan_clk : sys_clk;

    always #(SYS_HALF)  sys_clk  = ~sys_clk;
    always #(SCAN_HALF) scan_clk = ~scan_clk;

    clkfan_top #(.NUM_OUT(NUM)) u_clkfan_top (
        .sys_clk  (sys_clk),
        .scan_clk (scan_clk),
        .sel_scan (sel_line),
        .en_n     (en_n),
        .rst_n    (rst_n),
        .clk_out  (clk_out)
    );

    task automatic check_vec(input string req, input logic [NUM-1:0] act,
                             input logic [NUM-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // R1 R2 R8: measure every output pulse width
    always @(posedge clk_out[0]) rise_t = $realtime;
    always @(negedge clk_out[0]) begin
        if (mon_on) begin
            realtime w;
            w = $realtime - rise_t;
            n_tests++;
            if (w < cur_half - 0.01 || w > cur_half + 0.01) begin
                n_fail++;
                $display("FAIL R8/%s pulse width: actual %0.3f expected %0.3f",
                         cur_sel ? "R2" : "R1", w, cur_half);
            end
        end
    end

    task automatic select(input logic s, input logic drive);
        en_n = 1'b1;
        repeat (3) @(negedge ref_clk);
        mon_on  = 1'b0;
        sel_oe  = drive;
        sel_drv = s;
        cur_sel = s;
        cur_half = s ? SCAN_HALF : SYS_HALF;
        repeat (2) @(negedge ref_clk);
        #0.3;
        check_vec("R4 disabled after select", clk_out, '0);
        mon_on = 1'b1;
    endtask

    // Enable then disable at a given phase after a rising edge of the selected clock
    task automatic en_case(input real phase);
        @(posedge ref_clk);
        #(phase);
        en_n = 1'b0;
        if (phase < cur_half) begin
            #0.1;
            check_vec("R5 no start mid-high", clk_out, '0);
        end else begin
            @(posedge ref_clk); #0.2;
            check_vec("R5 no start before falling edge", clk_out, '0);
        end
        @(negedge ref_clk); #0.2;
        check_vec("R10 low phase", clk_out, '0);
        @(posedge ref_clk); #0.2;
        check_vec("R5 start after falling edge", clk_out, ONES);
        repeat (2) @(posedge ref_clk);
        #(phase);
        en_n = 1'b1;
        if (phase < cur_half) begin
            #0.1;
            check_vec("R6 high phase completes", clk_out, ONES);
        end else begin
            @(posedge ref_clk); #0.2;
            check_vec("R6 last high before falling edge", clk_out, ONES);
        end
        @(negedge ref_clk);
        @(posedge ref_clk); #0.2;
        check_vec("R4 stopped after falling edge", clk_out, '0);
        repeat (2) @(posedge ref_clk);
        #0.2;
        check_vec("R4 stays off", clk_out, '0);
    endtask

    task automatic sweep();
        for (int k = 0; k < 8; k++) begin
            en_case(cur_half * 2.0 * real'(2 * k + 1) / 16.0);
        end
    endtask

    task automatic finish_report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual hang expected completion");
        finish_report();
    end

    initial begin
        // R9: reset holds outputs low even with enable active
        en_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge sys_clk); #0.5;
            check_vec("R9 reset low", clk_out, '0);
        end
        en_n = 1'b1;
        #0.7;
        rst_n = 1'b1;
        repeat (3) @(posedge sys_clk);
        #0.5;
        check_vec("R9 low after release", clk_out, '0);

        // R3: undriven select line selects the system clock
        select(1'b0, 1'b0);
        sweep();
        // R1: driven low
        select(1'b0, 1'b1);
        sweep();
        // R2: scan clock
        select(1'b1, 1'b1);
        sweep();
        // R7 R2: long enabled run on scan clock with level checks
        en_n = 1'b0;
        @(negedge ref_clk);
        for (int i = 0; i < 6; i++) begin
            @(posedge ref_clk); #1.0;
            check_vec("R7 all equal high", clk_out, ONES);
            @(negedge ref_clk); #1.0;
            check_vec("R7 all equal low", clk_out, '0);
        end
        // back to system clock, then reset while enabled
        select(1'b0, 1'b1);
        en_n = 1'b0;
        repeat (3) @(negedge ref_clk);
        @(posedge ref_clk); #0.5;
        check_vec("R1 enabled high", clk_out, ONES);
        mon_on = 1'b0;
        #0.5;
        rst_n = 1'b0;
        #0.1;
        check_vec("R9 async reset mid-high", clk_out, '0);
        finish_report();
    end

endmodule